// File: doc/BRIEF.md
# Flag-Steered SPI Slave Link

This block is the device side of a host-controlled serial link. The host drives the select, clock and data-in lines and generates every transfer; the block never starts one. Outbound packets are written into a local byte buffer by the rest of the chip. Two status lines tell the host what the next transfer will do. One line says that at least one complete packet is waiting. The other line is a clear-to-send indicator that says the slave is still busy with an earlier request.

No command byte sets the direction of a transfer. The packet-waiting flag does, sampled at the moment select goes low. If a packet is waiting, the transfer is a read: the head packet is shifted out and the host's data is thrown away. If no packet is waiting, the transfer is a write: the host's bytes are delivered to the chip and the data-out line stays low. Select going low also raises the busy flag. The flag stays up until the chip reports through a done pulse that the command has finished. The slave drops any transfer the host starts while busy is up, and the host gets no indication of this. A single configuration input inverts the active level of both flags.

All SPI pins are synchronised into the system clock domain. The serial clock must therefore run several times slower than the system clock. Transfers use SPI mode 0, most significant bit first.

Top module: `spiFlagSlave`

## Requirements
- R1: After reset both flags are at their inactive level, `spiMiso` is 0, `pushReady` is 1, and no receive strobe fires.
- R2: The packet-waiting flag is active exactly while at least one complete packet is in the buffer. A packet is complete once its byte with `pushLast`=1 has been accepted.
- R3: A transfer that starts while no packet is waiting is a write. Each group of 8 bits sampled on rising `spiSclk`, first bit as bit 7, appears as one `rxValid` pulse on `rxByte`. `spiMiso` stays 0 throughout, and `rxFrameEnd` pulses once when select is released.
- R4: A transfer that starts while a packet is waiting is a read. The head packet's bytes are driven on `spiMiso` MSB first. The first bit is valid before the first rising edge and each later bit changes after a falling edge. Host data produces no `rxValid`.
- R5: During a read, every byte clocked after the packet's last byte reads as 0x00.
- R6: A packet leaves the buffer only when all of its bytes were clocked out and select was then released. After a partial read, the next read sends the same packet again from its first byte.
- R7: The busy flag becomes active as soon as an accepted transfer lowers select. It stays active until a `cmdDone` pulse arrives, including after select is released.
- R8: A transfer started while busy is active is discarded. `spiMiso` stays 0, no receive strobe fires, the buffer keeps its packets, and busy is unchanged.
- R9: With `cfgFlagsLow`=1 both flags are active low; with 0 they are active high.
- R10: The direction chosen when select falls holds until select rises. A packet that becomes complete during a write does not turn that write into a read.
- R11: `pushReady` is 0 when the buffer holds `BUF_DEPTH` unread bytes, and a push offered in that state is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgFlagsLow | input | 1 | 1 makes both status flags active low |
| spiSclk | input | 1 | Serial clock from the host, idles low |
| spiCsN | input | 1 | Active-low select from the host |
| spiMosi | input | 1 | Serial data from the host |
| spiMiso | output | 1 | Serial data to the host |
| availFlag | output | 1 | Packet-waiting flag to the host |
| busyFlag | output | 1 | Clear-to-send / busy flag to the host |
| pushValid | input | 1 | Offer one outbound byte |
| pushData | input | DATA_W | Outbound byte |
| pushLast | input | 1 | Marks the final byte of a packet |
| pushReady | output | 1 | Buffer has room for a byte |
| rxValid | output | 1 | One-cycle strobe for a received byte |
| rxByte | output | DATA_W | Received byte |
| rxFrameEnd | output | 1 | One-cycle strobe when a write transfer ends |
| cmdDone | input | 1 | Pulse when the requested command has finished |

## Verification
The bench builds the block with `BUF_DEPTH` = 8. With that depth a single eight-byte packet fills the buffer, so the full condition and a push dropped while full can be reached in one short scenario. A nine-byte read can then cover the zero padding past the end. `DATA_W` stays at 8 and `SYNC_STAGES` at 2. With the serial clock at one sixteenth of the system clock rate, every bit update lands well inside a half period of the serial clock.

// File: rtl/spiFlagPkg.sv
package spiFlagPkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2,
    PH_DROP  = 2'd3
  } phaseT;

  typedef struct packed {
    logic txnStart;   // accepted select fall
    logic txnRead;    // read transfer in progress
    logic txnWrite;   // write transfer in progress
    logic loadFirst;  // load head byte into tx shifter
    logic loadNext;   // load following byte at a byte boundary
    logic shiftOut;   // advance tx shifter by one bit
    logic sampleIn;   // capture one host bit
    logic byteDone;   // eighth bit of a byte captured
    logic endRead;    // select released after a read
    logic endWrite;   // select released after a write
  } strobeT;

endpackage

// File: rtl/spiFlagCtrl.sv
module spiFlagCtrl
  import spiFlagPkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   spiSclk,
  input  logic   spiCsN,
  input  logic   spiMosi,
  input  logic   pktAvail,
  input  logic   cmdDone,
  output strobeT strobe,
  output phaseT  phase,
  output logic   busy,
  output logic   mosiBit
);

  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  logic [SYNC_STAGES-1:0] sclkSync, csSync, mosiSync;
  logic sclkDly, csDly;
  logic sclkNow, csNow;
  logic sclkRise, sclkFall, csFall, csRise;
  logic [BIT_W-1:0] bitCnt;
  logic pendLoad;
  logic active;
  phaseT phaseNext;

  // input synchronisers, select and clock idle at their inactive levels
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync <= '0;
      csSync   <= '1;
      mosiSync <= '0;
      sclkDly  <= 1'b0;
      csDly    <= 1'b1;
    end else begin
      sclkSync <= {sclkSync[SYNC_STAGES-2:0], spiSclk};
      csSync   <= {csSync[SYNC_STAGES-2:0], spiCsN};
      mosiSync <= {mosiSync[SYNC_STAGES-2:0], spiMosi};
      sclkDly  <= sclkSync[SYNC_STAGES-1];
      csDly    <= csSync[SYNC_STAGES-1];
    end
  end

  assign sclkNow  = sclkSync[SYNC_STAGES-1];
  assign csNow    = csSync[SYNC_STAGES-1];
  assign mosiBit  = mosiSync[SYNC_STAGES-1];
  assign sclkRise = sclkNow & ~sclkDly;
  assign sclkFall = ~sclkNow & sclkDly;
  assign csFall   = ~csNow & csDly;
  assign csRise   = csNow & ~csDly;

  assign active = (phase == PH_READ) || (phase == PH_WRITE);

  always_comb begin
    strobe           = '0;
    strobe.txnStart  = (phase == PH_IDLE) && csFall && !busy;
    strobe.txnRead   = (phase == PH_READ);
    strobe.txnWrite  = (phase == PH_WRITE);
    strobe.loadFirst = strobe.txnStart && pktAvail;
    strobe.sampleIn  = active && sclkRise;
    strobe.byteDone  = strobe.sampleIn && (bitCnt == LAST_BIT);
    strobe.loadNext  = active && sclkFall && pendLoad;
    strobe.shiftOut  = active && sclkFall && !pendLoad;
    strobe.endRead   = (phase == PH_READ) && csRise;
    strobe.endWrite  = (phase == PH_WRITE) && csRise;
  end

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_IDLE: begin
        if (csFall) begin
          if (busy)          phaseNext = PH_DROP;
          else if (pktAvail) phaseNext = PH_READ;
          else               phaseNext = PH_WRITE;
        end
      end
      PH_READ, PH_WRITE, PH_DROP: begin
        if (csRise) phaseNext = PH_IDLE;
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      bitCnt   <= '0;
      pendLoad <= 1'b0;
      busy     <= 1'b0;
    end else begin
      phase <= phaseNext;

      if (strobe.txnStart) begin
        bitCnt <= '0;
      end else if (strobe.sampleIn) begin
        bitCnt <= strobe.byteDone ? '0 : bitCnt + 1'b1;
      end

      if (strobe.txnStart)       pendLoad <= 1'b0;
      else if (strobe.byteDone)  pendLoad <= 1'b1;
      else if (strobe.loadNext)  pendLoad <= 1'b0;

      if (strobe.txnStart)  busy <= 1'b1;
      else if (cmdDone)     busy <= 1'b0;
    end
  end

endmodule

// File: rtl/spiFlagPath.sv
module spiFlagPath
  import spiFlagPkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int BUF_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  logic              mosiBit,
  input  logic              pushValid,
  input  logic [DATA_W-1:0] pushData,
  input  logic              pushLast,
  output logic              pushReady,
  output logic              pktAvail,
  output logic [$clog2(BUF_DEPTH):0] pktCount,
  output logic              spiMiso,
  output logic              rxValid,
  output logic [DATA_W-1:0] rxByte,
  output logic              rxFrameEnd
);

  localparam int PTR_W = $clog2(BUF_DEPTH);
  localparam int CNT_W = PTR_W + 1;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BUF_DEPTH);

  // each entry: {last-of-packet tag, data byte}
  logic [DATA_W:0] bufMem [BUF_DEPTH];

  logic [CNT_W-1:0] wrPtr, rdCommit, rdSpec, fill;
  logic [DATA_W:0]  headWord, specWord;
  logic             pushAccept, pktInc, commit;
  logic [DATA_W-1:0] txShift, rxShift;
  logic             curLast, curReal, sentAll;

  assign fill       = wrPtr - rdCommit;
  assign pushReady  = (fill != FULL_CNT);
  assign pushAccept = pushValid && pushReady;
  assign pktInc     = pushAccept && pushLast;
  assign commit     = strobe.endRead && sentAll;
  assign pktAvail   = (pktCount != '0);
  assign headWord   = bufMem[rdCommit[PTR_W-1:0]];
  assign specWord   = bufMem[rdSpec[PTR_W-1:0]];
  assign spiMiso    = strobe.txnRead && txShift[DATA_W-1];

  always_ff @(posedge clk) begin
    if (pushAccept) bufMem[wrPtr[PTR_W-1:0]] <= {pushLast, pushData};
  end

  // buffer pointers and packet count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdCommit <= '0;
      rdSpec   <= '0;
      pktCount <= '0;
    end else begin
      if (pushAccept) wrPtr <= wrPtr + 1'b1;

      if (strobe.endRead) begin
        if (sentAll) rdCommit <= rdSpec;
        else         rdSpec   <= rdCommit;
      end else if (strobe.byteDone && strobe.txnRead && curReal) begin
        rdSpec <= rdSpec + 1'b1;
      end

      unique case ({pktInc, commit})
        2'b10:   pktCount <= pktCount + 1'b1;
        2'b01:   pktCount <= pktCount - 1'b1;
        default: pktCount <= pktCount;
      endcase
    end
  end

  // transmit shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      curLast <= 1'b0;
      curReal <= 1'b0;
      sentAll <= 1'b0;
    end else begin
      if (strobe.loadFirst) begin
        txShift <= headWord[DATA_W-1:0];
        curLast <= headWord[DATA_W];
        curReal <= 1'b1;
        sentAll <= 1'b0;
      end else if (strobe.txnStart) begin
        txShift <= '0;
        curReal <= 1'b0;
        sentAll <= 1'b0;
      end else begin
        if (strobe.byteDone && strobe.txnRead && curReal && curLast) begin
          sentAll <= 1'b1;
        end
        if (strobe.loadNext && strobe.txnRead) begin
          if (sentAll) begin
            txShift <= '0;
            curReal <= 1'b0;
          end else begin
            txShift <= specWord[DATA_W-1:0];
            curLast <= specWord[DATA_W];
            curReal <= 1'b1;
          end
        end else if (strobe.shiftOut && strobe.txnRead) begin
          txShift <= {txShift[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  // receive shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift    <= '0;
      rxValid    <= 1'b0;
      rxByte     <= '0;
      rxFrameEnd <= 1'b0;
    end else begin
      rxValid    <= 1'b0;
      rxFrameEnd <= strobe.endWrite;
      if (strobe.txnStart) begin
        rxShift <= '0;
      end else if (strobe.sampleIn && strobe.txnWrite) begin
        rxShift <= {rxShift[DATA_W-2:0], mosiBit};
        if (strobe.byteDone) begin
          rxValid <= 1'b1;
          rxByte  <= {rxShift[DATA_W-2:0], mosiBit};
        end
      end
    end
  end

endmodule

// File: rtl/spiFlagSlave.sv
module spiFlagSlave
  import spiFlagPkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int BUF_DEPTH   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgFlagsLow,
  input  logic              spiSclk,
  input  logic              spiCsN,
  input  logic              spiMosi,
  output logic              spiMiso,
  output logic              availFlag,
  output logic              busyFlag,
  input  logic              pushValid,
  input  logic [DATA_W-1:0] pushData,
  input  logic              pushLast,
  output logic              pushReady,
  output logic              rxValid,
  output logic [DATA_W-1:0] rxByte,
  output logic              rxFrameEnd,
  input  logic              cmdDone
);

  localparam int CNT_W = $clog2(BUF_DEPTH) + 1;

  strobeT           strobe;
  phaseT            phase;
  logic             busy;
  logic             mosiBit;
  logic             pktAvail;
  logic [CNT_W-1:0] pktCount;

  spiFlagCtrl #(
    .DATA_W      (DATA_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .spiSclk  (spiSclk),
    .spiCsN   (spiCsN),
    .spiMosi  (spiMosi),
    .pktAvail (pktAvail),
    .cmdDone  (cmdDone),
    .strobe   (strobe),
    .phase    (phase),
    .busy     (busy),
    .mosiBit  (mosiBit)
  );

  spiFlagPath #(
    .DATA_W    (DATA_W),
    .BUF_DEPTH (BUF_DEPTH)
  ) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .mosiBit    (mosiBit),
    .pushValid  (pushValid),
    .pushData   (pushData),
    .pushLast   (pushLast),
    .pushReady  (pushReady),
    .pktAvail   (pktAvail),
    .pktCount   (pktCount),
    .spiMiso    (spiMiso),
    .rxValid    (rxValid),
    .rxByte     (rxByte),
    .rxFrameEnd (rxFrameEnd)
  );

  assign availFlag = pktAvail ^ cfgFlagsLow;
  assign busyFlag  = busy ^ cfgFlagsLow;

endmodule

// File: rtl/spiFlagSlaveChk.sv
module spiFlagSlaveChk
  import spiFlagPkg::*;
#(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input phaseT            phase,
  input strobeT           strobe,
  input logic             busy,
  input logic             cmdDone,
  input logic [CNT_W-1:0] pktCount,
  input logic             spiMiso,
  input logic             rxValid
);

  AST_BUSY_SETS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.txnStart |=> busy);  // R7

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !cmdDone) |=> busy);  // R7

  AST_WRITE_MISO_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_WRITE) |-> !spiMiso);  // R3

  AST_READ_NO_RX: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_READ) |-> !rxValid);  // R4

  AST_ONE_TX_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadFirst, strobe.loadNext, strobe.shiftOut}));  // R4

  AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DROP) |-> (!spiMiso && !rxValid));  // R8

  AST_REMOVE_ON_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (pktCount < $past(pktCount)) |-> $past(strobe.endRead));  // R6

endmodule

bind spiFlagSlave spiFlagSlaveChk #(.CNT_W($clog2(BUF_DEPTH) + 1)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .phase    (phase),
  .strobe   (strobe),
  .busy     (busy),
  .cmdDone  (cmdDone),
  .pktCount (pktCount),
  .spiMiso  (spiMiso),
  .rxValid  (rxValid)
);

// File: tb/spiFlagSlave_bench.sv
`timescale 1ns/100ps
module spiFlagSlave_bench;

  localparam int DEPTH = 8;
  localparam int HALF  = 40;   // half period of the serial clock in ns

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgFlagsLow = 1'b0;
  logic spiSclk = 1'b0, spiCsN = 1'b1, spiMosi = 1'b0;
  logic spiMiso, availFlag, busyFlag, pushReady, rxValid, rxFrameEnd;
  logic pushValid = 1'b0, pushLast = 1'b0, cmdDone = 1'b0;
  logic [7:0] pushData = '0;
  logic [7:0] rxByte;

  int checks = 0;
  int fails  = 0;
  int rxTotal = 0;
  int frameTotal = 0;
  logic [7:0] rxLog [64];
  logic [7:0] hostTx [16];
  logic [7:0] hostRx [16];

  always #2.5 clk = ~clk;

  spiFlagSlave #(.DATA_W(8), .BUF_DEPTH(DEPTH), .SYNC_STAGES(2)) u_spiFlagSlave (
    .clk(clk), .rstN(rstN), .cfgFlagsLow(cfgFlagsLow),
    .spiSclk(spiSclk), .spiCsN(spiCsN), .spiMosi(spiMosi), .spiMiso(spiMiso),
    .availFlag(availFlag), .busyFlag(busyFlag),
    .pushValid(pushValid), .pushData(pushData), .pushLast(pushLast), .pushReady(pushReady),
    .rxValid(rxValid), .rxByte(rxByte), .rxFrameEnd(rxFrameEnd), .cmdDone(cmdDone)
  );

  always @(negedge clk) begin
    if (rstN && rxValid) begin
      rxLog[rxTotal % 64] = rxByte;
      rxTotal++;
    end
    if (rstN && rxFrameEnd) frameTotal++;
  end

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, actual, expected);
    end
  endtask

  task automatic xfer(input int n);
    spiCsN = 1'b0;
    #HALF;
    for (int b = 0; b < n; b++) begin
      for (int k = 7; k >= 0; k--) begin
        spiMosi = hostTx[b][k];
        #HALF;
        spiSclk = 1'b1;
        hostRx[b][k] = spiMiso;
        #HALF;
        spiSclk = 1'b0;
      end
    end
    #HALF;
    spiCsN = 1'b1;
    #(2*HALF);
  endtask

  task automatic pushByte(input logic [7:0] d, input logic last);
    @(negedge clk);
    pushValid = 1'b1; pushData = d; pushLast = last;
    @(negedge clk);
    pushValid = 1'b0; pushLast = 1'b0;
  endtask

  task automatic pulseDone();
    @(negedge clk); cmdDone = 1'b1;
    @(negedge clk); cmdDone = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check(availFlag == 1'b0, "R1 avail", availFlag, 0);
    check(busyFlag == 1'b0, "R1 busy", busyFlag, 0);
    check(spiMiso == 1'b0, "R1 miso", spiMiso, 0);
    check(pushReady == 1'b1, "R1 pushReady", pushReady, 1);
    check(rxTotal == 0, "R1 no rx", rxTotal, 0);
  endtask

  task automatic t_write();
    int base = rxTotal;
    int fb = frameTotal;
    hostTx[0] = 8'hA5; hostTx[1] = 8'h3C; hostTx[2] = 8'h0F;
    spiCsN = 1'b0;
    #HALF;
    check(busyFlag == 1'b1, "R7 busy on select", busyFlag, 1);
    spiCsN = 1'b1;   // restore before the full transfer helper drives select
    #(2*HALF);
    pulseDone();
    // the short select above counted as a write with no bytes
    base = rxTotal; fb = frameTotal;
    xfer(3);
    check(rxTotal - base == 3, "R3 rx count", rxTotal - base, 3);
    for (int i = 0; i < 3; i++) begin
      check(rxLog[(base + i) % 64] == hostTx[i], "R3 rx byte", rxLog[(base + i) % 64], hostTx[i]);
      check(hostRx[i] == 8'h00, "R3 miso low", hostRx[i], 0);
    end
    check(frameTotal - fb == 1, "R3 frame end", frameTotal - fb, 1);
    check(busyFlag == 1'b1, "R7 busy held after release", busyFlag, 1);
    pulseDone();
    check(busyFlag == 1'b0, "R7 busy cleared by done", busyFlag, 0);
  endtask

  task automatic t_discard();
    int base;
    int fb;
    hostTx[0] = 8'h11;
    xfer(1);
    pulseDone();
    hostTx[0] = 8'h22;
    xfer(1);         // leaves busy active
    pushByte(8'h81, 1'b0);
    pushByte(8'h7E, 1'b1);
    check(availFlag == 1'b1, "R2 avail after packet", availFlag, 1);
    base = rxTotal; fb = frameTotal;
    hostTx[0] = 8'hFF; hostTx[1] = 8'hFF;
    xfer(2);
    check(rxTotal == base, "R8 no rx when dropped", rxTotal - base, 0);
    check(frameTotal == fb, "R8 no frame end", frameTotal - fb, 0);
    check(hostRx[0] == 8'h00 && hostRx[1] == 8'h00, "R8 miso low", hostRx[0], 0);
    check(availFlag == 1'b1, "R8 packet kept", availFlag, 1);
    check(busyFlag == 1'b1, "R8 busy unchanged", busyFlag, 1);
    pulseDone();
  endtask

  task automatic t_read();
    int base = rxTotal;
    for (int i = 0; i < 4; i++) hostTx[i] = 8'h55;
    xfer(4);
    check(hostRx[0] == 8'h81, "R4 byte0", hostRx[0], 8'h81);
    check(hostRx[1] == 8'h7E, "R4 byte1", hostRx[1], 8'h7E);
    check(hostRx[2] == 8'h00, "R5 pad0", hostRx[2], 0);
    check(hostRx[3] == 8'h00, "R5 pad1", hostRx[3], 0);
    check(rxTotal == base, "R4 host data ignored", rxTotal - base, 0);
    check(availFlag == 1'b0, "R6 removed after full read", availFlag, 0);
    pulseDone();
  endtask

  task automatic t_partial();
    pushByte(8'hC3, 1'b0);
    pushByte(8'h5A, 1'b1);
    hostTx[0] = 8'h00; hostTx[1] = 8'h00;
    xfer(1);
    check(hostRx[0] == 8'hC3, "R6 partial byte", hostRx[0], 8'hC3);
    check(availFlag == 1'b1, "R6 kept after partial", availFlag, 1);
    pulseDone();
    xfer(2);
    check(hostRx[0] == 8'hC3 && hostRx[1] == 8'h5A, "R6 resent from start",
          {hostRx[0], hostRx[1]}, 16'hC35A);
    check(availFlag == 1'b0, "R6 removed", availFlag, 0);
    pulseDone();
  endtask

  task automatic t_twoPkts();
    pushByte(8'h12, 1'b1);
    pushByte(8'h34, 1'b0);
    pushByte(8'h56, 1'b1);
    xfer(1);
    check(hostRx[0] == 8'h12, "R2 first packet", hostRx[0], 8'h12);
    check(availFlag == 1'b1, "R2 second still waiting", availFlag, 1);
    pulseDone();
    xfer(2);
    check(hostRx[0] == 8'h34 && hostRx[1] == 8'h56, "R2 second packet",
          {hostRx[0], hostRx[1]}, 16'h3456);
    check(availFlag == 1'b0, "R2 empty", availFlag, 0);
    pulseDone();
  endtask

  task automatic t_dirHold();
    int base = rxTotal;
    hostTx[0] = 8'h9A; hostTx[1] = 8'hBC;
    fork
      xfer(2);
      begin
        #200;
        pushByte(8'hEE, 1'b1);
      end
    join
    check(rxTotal - base == 2, "R10 stays write", rxTotal - base, 2);
    check(rxLog[(base + 1) % 64] == 8'hBC, "R10 second byte", rxLog[(base + 1) % 64], 8'hBC);
    check(hostRx[1] == 8'h00, "R10 miso low", hostRx[1], 0);
    check(availFlag == 1'b1, "R10 packet queued", availFlag, 1);
    pulseDone();
    xfer(1);
    check(hostRx[0] == 8'hEE, "R10 later read", hostRx[0], 8'hEE);
    pulseDone();
  endtask

  task automatic t_polarity();
    cfgFlagsLow = 1'b1;
    #20;
    check(availFlag == 1'b1 && busyFlag == 1'b1, "R9 inactive high",
          {availFlag, busyFlag}, 2'b11);
    pushByte(8'h77, 1'b1);
    check(availFlag == 1'b0, "R9 avail active low", availFlag, 0);
    xfer(1);
    check(hostRx[0] == 8'h77, "R9 read data", hostRx[0], 8'h77);
    check(busyFlag == 1'b0, "R9 busy active low", busyFlag, 0);
    pulseDone();
    check(busyFlag == 1'b1 && availFlag == 1'b1, "R9 idle levels",
          {availFlag, busyFlag}, 2'b11);
    cfgFlagsLow = 1'b0;
    #20;
  endtask

  task automatic t_full();
    for (int i = 0; i < DEPTH; i++) pushByte(8'hB0 + 8'(i), (i == DEPTH - 1));
    check(pushReady == 1'b0, "R11 full", pushReady, 0);
    pushByte(8'hDD, 1'b1);   // dropped
    check(availFlag == 1'b1, "R11 avail", availFlag, 1);
    xfer(DEPTH + 1);
    for (int i = 0; i < DEPTH; i++)
      check(hostRx[i] == 8'hB0 + 8'(i), "R11 stored byte", hostRx[i], 8'hB0 + i);
    check(hostRx[DEPTH] == 8'h00, "R11 extra push dropped", hostRx[DEPTH], 0);
    check(pushReady == 1'b1, "R11 room again", pushReady, 1);
    check(availFlag == 1'b0, "R11 empty", availFlag, 0);
    pulseDone();
  endtask

  initial begin
    #500_000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #50;
    rstN = 1'b1;
    #20;
    t_reset();
    t_write();
    t_discard();
    t_read();
    t_partial();
    t_twoPkts();
    t_dirHold();
    t_polarity();
    t_full();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule